// File: doc/BRIEF.md
# Interrupt CPU Interface with Acknowledge

This block is the per-processor end of an interrupt controller. The distributor supplies, for every interrupt, an enable bit, a pending bit, an active bit, an 8-bit priority value and a target mask. The block keeps those interrupts that are enabled, pending, not active and aimed at its own processor, and picks the most urgent one. It raises `irq_req` when that candidate passes three tests: the interface is switched on, the candidate beats the priority mask, and the candidate is allowed to preempt the interrupt that is already being handled.

Software uses a small register window. Reading the acknowledge register takes the winning interrupt and tells the distributor to make it active. Writing the end-of-interrupt register tells the distributor to make the written interrupt inactive. The highest-pending register shows the winner without changing any state. The running-priority register reports the urgency of the work in progress.

A shallow stack holds the priorities that are currently active, so that nested handlers are tracked. Preemption looks only at the group part of a priority, and the binary point register chooses how many bits form that part.

Top module: `irq_cpu_port`

## Requirements
- R1: A read of offset 0x18 returns the ID [9:0] and source field [12:10] of the winner, or 1023 when no interrupt is eligible. An interrupt is eligible when it is enabled, pending, not active and its target bit CPU_ID is set. The winner is the lowest priority value, and the lowest ID wins a tie. This read activates nothing.
- R2: `irq_req` can be high only when the winner's priority value is strictly below the 8-bit mask held at offset 0x04. The mask resets to 0.
- R3: While bit 0 of the control register (offset 0x00) is 0, `irq_req` stays low. An acknowledge read in this state returns 1023.
- R4: A read of offset 0x0C while `irq_req` is high returns {19'b0, src[2:0], id[9:0]}. src is the requesting CPU for IDs 0–15 and 0 for all other IDs. In the cycle after the read, `act_set_vld` is high with `act_set_id` equal to that ID.
- R5: A read of offset 0x0C while `irq_req` is low returns 1023 and leaves `act_set_vld` low.
- R6: A write to offset 0x10 with an ID below NUM_IRQ pulses `act_clr_vld` in the next cycle, with `act_clr_id` equal to wdata[9:0]. A write with any other ID, 1023 included, gives no pulse.
- R7: Offset 0x14 reads 0xFF when nothing is active. Otherwise it reads the priority of the most recently acknowledged interrupt that has not yet ended. An end of interrupt for the most recent ID restores the previous value. An end of interrupt for any other ID leaves the value unchanged.
- R8: While an interrupt is active, `irq_req` also requires the winner's group priority to be strictly below the running group priority. The group priority is the priority value with bits [bp:0] cleared, where bp is the 3-bit binary point at offset 0x08.
- R9: When STACK_DEPTH interrupts are active, `irq_req` stays low.
- R10: Read-back gives control at [0], the mask at [7:0] and the binary point at [2:0]. Offset 0xFC returns the IDENT parameter. Any other offset reads 0. Every read appears on `reg_rdata` in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_rd | input | 1 | Read strobe; acknowledge side effect on this edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_en_vec | input | NUM_IRQ | Per-interrupt enable from distributor |
| irq_pend_vec | input | NUM_IRQ | Per-interrupt pending from distributor |
| irq_act_vec | input | NUM_IRQ | Per-interrupt active from distributor |
| irq_prio_flat | input | NUM_IRQ*8 | Priority values, 8 bits per interrupt |
| irq_tgt_flat | input | NUM_IRQ*TGT_W | Target masks, TGT_W bits per interrupt |
| sgi_src_flat | input | 16*SRC_W | Requesting CPU of each software interrupt |
| irq_req | output | 1 | Interrupt request to the processor |
| act_set_vld | output | 1 | Pending-to-active pulse |
| act_set_id | output | 10 | ID for the pending-to-active pulse |
| act_clr_vld | output | 1 | Active-to-inactive pulse |
| act_clr_id | output | 10 | ID for the active-to-inactive pulse |

## Verification
The arbiter is tried with several dozen pseudo-random mixes of enable, pending, active and target bits. Priorities are drawn from only four values, so ties are common, and these patterns separate lowest-value-first from lowest-ID-first ordering. The mask is swept over all 256 values against sixteen priorities, which exposes any non-strict comparison. A nested sequence switches the binary point between 0 and 7 and acknowledges interrupts into a full stack. It shows whether preemption compares group bits only, whether the running priority unwinds on end of interrupt, and whether a mismatched or spurious end of interrupt is handled correctly.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam logic [9:0] SPURIOUS_ID = 10'd1023;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MASK  = 8'h04;
  localparam logic [7:0] OFS_BINPT = 8'h08;
  localparam logic [7:0] OFS_ACK   = 8'h0C;
  localparam logic [7:0] OFS_EOI   = 8'h10;
  localparam logic [7:0] OFS_RUN   = 8'h14;
  localparam logic [7:0] OFS_HIGH  = 8'h18;
  localparam logic [7:0] OFS_IDENT = 8'hFC;

  typedef struct packed {
    logic [9:0] id;
    logic [7:0] prio;
  } act_entry_t;

  // Group part of a priority: bits [bp:0] cleared.
  function automatic logic [7:0] grp_prio(input logic [7:0] p, input logic [2:0] bp);
    logic [7:0] keep;
    keep = 8'hFE << bp;
    return p & keep;
  endfunction
endpackage

// File: rtl/cpuif_arbiter.sv
module cpuif_arbiter #(
  parameter int NUM_IRQ = 32,
  parameter int TGT_W   = 8,
  parameter int CPU_ID  = 0
) (
  input  logic [NUM_IRQ-1:0]       en_vec,
  input  logic [NUM_IRQ-1:0]       pend_vec,
  input  logic [NUM_IRQ-1:0]       act_vec,
  input  logic [NUM_IRQ*8-1:0]     prio_flat,
  input  logic [NUM_IRQ*TGT_W-1:0] tgt_flat,
  output logic                     best_vld,
  output logic [9:0]               best_id,
  output logic [7:0]               best_prio
);
  logic [NUM_IRQ-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_elig
      assign elig[g] = en_vec[g] & pend_vec[g] & ~act_vec[g] & tgt_flat[g*TGT_W + CPU_ID];
    end
  endgenerate

  // Ascending scan with strict compare: the lowest ID keeps a tie.
  always_comb begin
    best_vld  = 1'b0;
    best_id   = '0;
    best_prio = 8'hFF;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!best_vld || (prio_flat[i*8 +: 8] < best_prio))) begin
        best_vld  = 1'b1;
        best_id   = 10'(i);
        best_prio = prio_flat[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/cpuif_prio_stack.sv
module cpuif_prio_stack
  import cpuif_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_en,
  input  act_entry_t push_ent,
  input  logic       pop_en,
  input  logic [9:0] pop_id,
  output act_entry_t top_ent,
  output logic       empty,
  output logic       full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_m1;
  act_entry_t    ent_q [DEPTH];
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign cnt_m1  = cnt_q - 1'b1;
  assign top_ent = empty ? '0 : ent_q[cnt_m1[IW-1:0]];
  assign push_ok = push_en & ~full;
  assign pop_ok  = pop_en & ~empty & (top_ent.id == pop_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_ok && pop_ok) begin
      ent_q[cnt_m1[IW-1:0]] <= push_ent;
    end else if (push_ok) begin
      ent_q[cnt_q[IW-1:0]] <= push_ent;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_ok) begin
      cnt_q <= cnt_m1;
    end
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import cpuif_pkg::*;
#(
  parameter int          NUM_IRQ     = 32,
  parameter int          TGT_W       = 8,
  parameter int          CPU_ID      = 0,
  parameter int          SRC_W       = 3,
  parameter int          STACK_DEPTH = 4,
  parameter logic [31:0] IDENT       = 32'h0001_0A07
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               reg_addr,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [NUM_IRQ-1:0]       irq_en_vec,
  input  logic [NUM_IRQ-1:0]       irq_pend_vec,
  input  logic [NUM_IRQ-1:0]       irq_act_vec,
  input  logic [NUM_IRQ*8-1:0]     irq_prio_flat,
  input  logic [NUM_IRQ*TGT_W-1:0] irq_tgt_flat,
  input  logic [16*SRC_W-1:0]      sgi_src_flat,
  output logic                     irq_req,
  output logic                     act_set_vld,
  output logic [9:0]               act_set_id,
  output logic                     act_clr_vld,
  output logic [9:0]               act_clr_id
);
  localparam int PAD_W = 32 - 10 - SRC_W;

  // Named internal events (also watched by the checker).
  logic       ctrl_en_q;
  logic [7:0] pmr_q;
  logic [2:0] bpr_q;
  logic       best_vld;
  logic [9:0] best_id;
  logic [7:0] best_prio;
  logic       stk_empty, stk_full;
  act_entry_t top_ent;
  logic [7:0] run_prio;
  logic       preempt_ok;
  logic       ack_take;
  logic       eoi_hit;
  logic [SRC_W-1:0] src_of_best;
  logic [31:0] id_word;
  logic [31:0] rd_mux;

  logic [31:0] rdata_q;
  logic        set_vld_q, clr_vld_q;
  logic [9:0]  set_id_q, clr_id_q;

  cpuif_arbiter #(.NUM_IRQ(NUM_IRQ), .TGT_W(TGT_W), .CPU_ID(CPU_ID)) u_arb (
    .en_vec    (irq_en_vec),
    .pend_vec  (irq_pend_vec),
    .act_vec   (irq_act_vec),
    .prio_flat (irq_prio_flat),
    .tgt_flat  (irq_tgt_flat),
    .best_vld  (best_vld),
    .best_id   (best_id),
    .best_prio (best_prio)
  );

  cpuif_prio_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (ack_take),
    .push_ent ('{id: best_id, prio: best_prio}),
    .pop_en   (eoi_hit),
    .pop_id   (reg_wdata[9:0]),
    .top_ent  (top_ent),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  assign run_prio   = stk_empty ? 8'hFF : top_ent.prio;
  assign preempt_ok = stk_empty | (grp_prio(best_prio, bpr_q) < grp_prio(run_prio, bpr_q));
  assign irq_req    = ctrl_en_q & best_vld & (best_prio < pmr_q) & preempt_ok & ~stk_full;
  assign ack_take   = reg_rd & (reg_addr == OFS_ACK) & irq_req;
  assign eoi_hit    = reg_wr & (reg_addr == OFS_EOI) & (32'(reg_wdata[9:0]) < 32'(NUM_IRQ));

  always_comb begin
    src_of_best = '0;
    if (best_id < 10'd16) src_of_best = sgi_src_flat[best_id[3:0]*SRC_W +: SRC_W];
  end

  assign id_word = {{PAD_W{1'b0}}, src_of_best, best_id};

  always_comb begin
    case (reg_addr)
      OFS_CTRL:  rd_mux = {31'b0, ctrl_en_q};
      OFS_MASK:  rd_mux = {24'b0, pmr_q};
      OFS_BINPT: rd_mux = {29'b0, bpr_q};
      OFS_ACK:   rd_mux = irq_req  ? id_word : {22'b0, SPURIOUS_ID};
      OFS_RUN:   rd_mux = {24'b0, run_prio};
      OFS_HIGH:  rd_mux = best_vld ? id_word : {22'b0, SPURIOUS_ID};
      OFS_IDENT: rd_mux = IDENT;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q <= 1'b0;
      pmr_q     <= 8'h00;
      bpr_q     <= 3'd0;
      rdata_q   <= '0;
      set_vld_q <= 1'b0;
      set_id_q  <= '0;
      clr_vld_q <= 1'b0;
      clr_id_q  <= '0;
    end else begin
      set_vld_q <= ack_take;
      clr_vld_q <= eoi_hit;
      if (ack_take) set_id_q <= best_id;
      if (eoi_hit)  clr_id_q <= reg_wdata[9:0];
      if (reg_rd)   rdata_q  <= rd_mux;
      if (reg_wr) begin
        case (reg_addr)
          OFS_CTRL:  ctrl_en_q <= reg_wdata[0];
          OFS_MASK:  pmr_q     <= reg_wdata[7:0];
          OFS_BINPT: bpr_q     <= reg_wdata[2:0];
          default:   ;
        endcase
      end
    end
  end

  assign reg_rdata   = rdata_q;
  assign act_set_vld = set_vld_q;
  assign act_set_id  = set_id_q;
  assign act_clr_vld = clr_vld_q;
  assign act_clr_id  = clr_id_q;
endmodule

// File: rtl/irq_cpu_port_chk.sv
module irq_cpu_port_chk
  import cpuif_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  reg_addr,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        irq_req,
  input logic        act_set_vld,
  input logic        act_clr_vld,
  input logic [9:0]  act_clr_id,
  input logic [7:0]  best_prio,
  input logic [7:0]  pmr_q,
  input logic        stk_empty,
  input logic        stk_full,
  input logic [7:0]  top_prio,
  input logic [7:0]  run_prio
);
  p_mask_strict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (best_prio < pmr_q));

  p_set_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_set_vld |-> $past(reg_rd && (reg_addr == OFS_ACK) && irq_req));

  p_spurious_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == OFS_ACK) && !irq_req) |=> (!act_set_vld && (reg_rdata == 32'd1023)));

  p_clr_after_eoi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_clr_vld |-> ($past(reg_wr && (reg_addr == OFS_EOI)) && (act_clr_id == $past(reg_wdata[9:0]))));

  p_idle_run_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == OFS_RUN) && stk_empty) |=> (reg_rdata == 32'h0000_00FF));

  p_push_more_urgent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_set_vld && !$past(stk_empty)) |-> (top_prio < $past(run_prio)));

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_req);
endmodule

bind irq_cpu_port irq_cpu_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .irq_req     (irq_req),
  .act_set_vld (act_set_vld),
  .act_clr_vld (act_clr_vld),
  .act_clr_id  (act_clr_id),
  .best_prio   (best_prio),
  .pmr_q       (pmr_q),
  .stk_empty   (stk_empty),
  .stk_full    (stk_full),
  .top_prio    (top_ent.prio),
  .run_prio    (run_prio)
);

// File: tb/irq_cpu_port_bench.sv
module irq_cpu_port_bench;
  localparam int N = 32;
  localparam logic [31:0] IDV = 32'h0001_0A07;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [7:0]   reg_addr = '0;
  logic         reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [N-1:0] en_v = '0, pend_v = '0, act_v = '0;
  logic [N*8-1:0] prio_f = '0, tgt_f = '0;
  logic [47:0]  src_f = '0;
  logic         irq_req, act_set_vld, act_clr_vld;
  logic [9:0]   act_set_id, act_clr_id;

  int errors = 0;
  int checks = 0;

  irq_cpu_port u_irq_cpu_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en_vec(en_v), .irq_pend_vec(pend_v),
    .irq_act_vec(act_v), .irq_prio_flat(prio_f), .irq_tgt_flat(tgt_f), .sgi_src_flat(src_f),
    .irq_req(irq_req), .act_set_vld(act_set_vld), .act_set_id(act_set_id),
    .act_clr_vld(act_clr_vld), .act_clr_id(act_clr_id)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Register read; the bench plays the distributor on the activate pulse.
  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic sv, output logic [9:0] sid);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; sv = act_set_vld; sid = act_set_id;
    if (sv) begin pend_v[sid] = 1'b0; act_v[sid] = 1'b1; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v, output logic cv, output logic [9:0] cid);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    cv = act_clr_vld; cid = act_clr_id;
    if (cv) act_v[cid] = 1'b0;
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  // Reference winner: smallest {priority, id} key among eligible sources.
  function automatic logic [31:0] ref_high();
    logic [17:0] key;
    logic        found;
    key = '1; found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (en_v[i] && pend_v[i] && !act_v[i] && tgt_f[i*8] && ({prio_f[i*8 +: 8], 10'(i)} < key)) begin
        key = {prio_f[i*8 +: 8], 10'(i)}; found = 1'b1;
      end
    end
    if (!found) return 32'd1023;
    if (key[9:0] < 16) return {19'b0, src_f[key[3:0]*3 +: 3], key[9:0]};
    return {22'b0, key[9:0]};
  endfunction

  function automatic logic grp_less(input logic [7:0] a, input logic [7:0] b, input int bp);
    return (a >> (bp + 1)) < (b >> (bp + 1));
  endfunction

  task automatic arm(input int id, input logic [7:0] p);
    en_v[id] = 1'b1; pend_v[id] = 1'b1; tgt_f[id*8] = 1'b1; prio_f[id*8 +: 8] = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, r;
    logic sv, cv;
    logic [9:0] sid, cid;
    logic [N-1:0] pend_snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check("R2 reset irq_req", 32'(irq_req), 0);
    rd(8'h00, d, sv, sid); check("R10 reset ctrl", d, 0);
    rd(8'h04, d, sv, sid); check("R10 reset mask", d, 0);
    rd(8'h14, d, sv, sid); check("R7 idle running", d, 32'hFF);

    // Register read-back
    wr(8'h04, 32'hFFFF_FFA5, cv, cid); rd(8'h04, d, sv, sid); check("R10 mask", d, 32'hA5);
    wr(8'h08, 32'hFFFF_FFFF, cv, cid); rd(8'h08, d, sv, sid); check("R10 binpt", d, 32'h7);
    wr(8'h00, 32'h3, cv, cid);         rd(8'h00, d, sv, sid); check("R10 ctrl", d, 32'h1);
    rd(8'hFC, d, sv, sid); check("R10 ident", d, IDV);
    rd(8'h20, d, sv, sid); check("R10 unused", d, 0);
    wr(8'h00, 32'h0, cv, cid);

    // R1: arbitration sweep over pseudo-random patterns with many ties
    r = 32'h1234_5678;
    for (int k = 0; k < 48; k++) begin
      r = xs(r); en_v = r;
      r = xs(r); pend_v = r | (k == 0 ? 32'h0 : 32'h0);
      if (k == 0) pend_v = '0;
      r = xs(r); act_v = r; r = xs(r); act_v = act_v & r;
      for (int i = 0; i < N; i++) begin
        r = xs(r);
        prio_f[i*8 +: 8] = {r[1:0], 6'b0};
        tgt_f[i*8 +: 8] = r[15:8] | 8'(k[0] ? 1 : 0);
      end
      r = xs(r); src_f[31:0] = r; r = xs(r); src_f[47:32] = r[15:0];
      pend_snap = pend_v;
      rd(8'h18, d, sv, sid);
      check("R1 highest pending", d, ref_high());
      check("R1 no activate", 32'(sv), 0);
      check("R1 pending kept", 32'(pend_v == pend_snap), 1);
    end
    en_v = '0; pend_v = '0; act_v = '0; prio_f = '0; tgt_f = '0; src_f = '0;

    // R2: strict mask compare swept exhaustively
    wr(8'h00, 32'h1, cv, cid);
    wr(8'h08, 32'h0, cv, cid);
    for (int p = 0; p < 256; p += 17) begin
      arm(5, 8'(p));
      for (int m = 0; m < 256; m++) begin
        wr(8'h04, 32'(m), cv, cid);
        check("R2 mask strict", 32'(irq_req), 32'(p < m));
      end
    end
    en_v = '0; pend_v = '0;

    // R3/R5: interface off
    arm(7, 8'h10);
    wr(8'h04, 32'hFF, cv, cid);
    wr(8'h00, 32'h0, cv, cid);
    check("R3 off no request", 32'(irq_req), 0);
    rd(8'h0C, d, sv, sid);
    check("R3 off ack spurious", d, 32'd1023);
    check("R5 no activate", 32'(sv), 0);
    wr(8'h00, 32'h1, cv, cid);
    check("R3 on request", 32'(irq_req), 1);
    en_v = '0; pend_v = '0;

    // R4/R7/R8: nesting and preemption
    src_f[3*3 +: 3] = 3'd5;
    arm(3, 8'h80);
    rd(8'h0C, d, sv, sid);
    check("R4 sgi ack word", d, 32'h1403);
    check("R4 activate id", {22'b0, sid}, 3);
    rd(8'h14, d, sv, sid); check("R7 running after ack", d, 32'h80);
    arm(20, 8'h81);
    check("R8 same group no preempt", 32'(irq_req), 32'(grp_less(8'h81, 8'h80, 0)));
    rd(8'h18, d, sv, sid); check("R1 shows blocked winner", d, 20);
    prio_f[20*8 +: 8] = 8'h7E;
    @(negedge clk);
    check("R8 urgent group preempts", 32'(irq_req), 32'(grp_less(8'h7E, 8'h80, 0)));
    wr(8'h08, 32'h7, cv, cid);
    check("R8 bp7 no preempt", 32'(irq_req), 32'(grp_less(8'h7E, 8'h80, 7)));
    wr(8'h08, 32'h0, cv, cid);
    rd(8'h0C, d, sv, sid);
    check("R4 non-sgi ack word", d, 20);
    check("R4 activate pulse", 32'(sv), 1);
    rd(8'h14, d, sv, sid); check("R7 nested running", d, 32'h7E);
    wr(8'h10, 32'd9, cv, cid);
    check("R6 clear pulse other id", {21'b0, cv, cid}, {21'b0, 1'b1, 10'd9});
    rd(8'h14, d, sv, sid); check("R7 mismatched end keeps", d, 32'h7E);
    wr(8'h10, 32'd20, cv, cid);
    check("R6 clear id", {22'b0, cid}, 20);
    rd(8'h14, d, sv, sid); check("R7 unwinds", d, 32'h80);
    wr(8'h10, 32'd1023, cv, cid); check("R6 spurious end ignored", 32'(cv), 0);
    wr(8'h10, 32'd40, cv, cid);   check("R6 out of range ignored", 32'(cv), 0);
    rd(8'h14, d, sv, sid); check("R7 unchanged after ignored", d, 32'h80);
    wr(8'h10, 32'd3, cv, cid);
    rd(8'h14, d, sv, sid); check("R7 back to idle", d, 32'hFF);
    en_v = '0; pend_v = '0;

    // R9: fill the stack
    for (int k = 0; k < 4; k++) begin
      arm(10 + k, 8'(8'h80 - 8'(k * 32)));
      rd(8'h0C, d, sv, sid);
      check("R9 chain ack", d, 32'(10 + k));
    end
    arm(14, 8'h00);
    check("R9 full blocks", 32'(irq_req), 0);
    for (int k = 3; k >= 0; k--) wr(8'h10, 32'(10 + k), cv, cid);
    rd(8'h14, d, sv, sid); check("R7 idle after unwinding", d, 32'hFF);
    check("R9 request after drain", 32'(irq_req), 1);
    rd(8'h0C, d, sv, sid); check("R4 ack after drain", d, 14);
    wr(8'h10, 32'd14, cv, cid);
    rd(8'h0C, d, sv, sid);
    check("R5 nothing pending", d, 32'd1023);
    check("R5 no activate", 32'(sv), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule